// File: doc/BRIEF.md
# Serial Block-Write Configuration Register Slave

This block is the control-register front end of a clock generator. It watches a two-wire SMBus through synchronizing flip-flops on the system clock and finds start and stop conditions. It takes part only in block-write transfers sent to its own address byte. Each accepted data byte is placed in a small bank of configuration bytes, and the whole bank is presented as one flat parallel bus to the clock-gating and divider logic around it.

A transfer is built from four parts. First comes the address byte 0xD2, which is the write direction. Next comes a command byte that must be zero. Then a count byte gives how many data bytes follow, from 1 to 32. The data bytes come last and always land from configuration byte 0 upward. The block acknowledges a byte by holding SDA low through the ninth clock. A byte the block refuses gets no acknowledge, and the block then stays silent until the next start. Data bytes whose index lies past the writable bank are acknowledged and dropped. Some bits can never be written. These include the fixed identification byte, the live state of the CPU stop input, and the strap inputs, which are captured once after reset.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, the bytes on cfg_bus (byte k at bits 8k+7..8k) read: byte1 0x07, byte2 0x7F, byte3 0xC7, byte4 0x3F, byte5 0x00, byte6 0x08. Byte0 has its writable bits at 0.
- R2: An address byte of 0xD2 is acknowledged. Any other address byte, including 0xD3 (the read direction), gets no acknowledge, and the rest of that transfer is ignored up to the next start.
- R3: A command byte of 0x00 is acknowledged. Any other command byte gets no acknowledge and writes nothing.
- R4: A count byte from 1 to 32 is acknowledged. A count of 0 or above 32 gets no acknowledge, and the data bytes that follow write nothing.
- R5: Data bytes are received most significant bit first. Each is acknowledged and written to byte 0, 1, 2 and so on in turn. Only writable bits change: masks 0xA8, 0x7F, 0x7F, 0xFF, 0x3F and 0x3F for bytes 0 through 5.
- R6: A stop after some complete data bytes keeps those bytes written. A byte cut short by the stop changes nothing.
- R7: Data bytes with index 6 or higher, up to the count, are acknowledged and discarded. Byte 6 always reads 0x08.
- R8: Once the number of data bytes given by the count has been received, any further bytes get no acknowledge and write nothing.
- R9: In byte 0, bit 4 follows cpu_stop_n with no clock delay. Bits 2 and 1 show strap_in[1] and strap_in[0] as captured in the first cycle after reset. Bit 0 reads 1 and bit 6 reads 0.
- R10: sda_pull rises only while the synchronized SCL is low after the eighth bit. It falls only while SCL is low, at the end of the ninth clock. It is low at all other times.
- R11: A start in the middle of a transfer begins a new transfer with a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| cpu_stop_n | input | 1 | Live CPU stop pin, shown in byte 0 bit 4 |
| strap_in | input | 2 | Frequency-select straps, captured once after reset |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| cfg_bus | output | 56 | Configuration bytes 0 to 6, byte k at bits 8k+7..8k |

## Verification
A falling SCL edge passes through two synchronizer flops and one edge-detect stage, so sda_pull changes on the third clock edge after that fall, and a register write shows on cfg_bus on the fourth. The bench drives each bus half-period for eight clocks. It samples the acknowledge in the middle of the SCL high phase and checks the release one half-period after SCL falls. While a byte write is pending, it suspends its cycle-by-cycle compare of cfg_bus against the behavioural model for eight clocks, then updates the model and resumes. The strap and stop-pin bits are compared in the same cycle they are driven, because they pass through no register.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] ID_VALUE = 8'h08;

  // writable bits per configuration byte
  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      0:       return 8'hA8;
      1:       return 8'h7F;
      2:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h3F;
      5:       return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  // power-on value of the stored bits per configuration byte
  function automatic logic [7:0] rst_value(input int idx);
    case (idx)
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced,
  output logic [LINES-1:0] prev
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-1:0], raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign synced[g] = chain_q[STAGES-1];
    assign prev[g]   = chain_q[STAGES];
  end

endmodule

// File: rtl/smb_frame_engine.sv
module smb_frame_engine
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE = 8'hD2,
  parameter int         MAX_COUNT = 32,
  parameter int         RW_BYTES  = 6,
  parameter int         IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             scl_p,
  input  logic             sda_s,
  input  logic             sda_p,
  output logic             ack_pull,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  localparam int CNT_W = $clog2(MAX_COUNT + 1);

  phase_t           phase_q, phase_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             ack_q, ack_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             wr_en_q, wr_en_d;
  logic [IDX_W-1:0] wr_idx_q, wr_idx_d;
  logic [7:0]       wr_data_q, wr_data_d;

  logic scl_rise, scl_fall, start_ev, stop_ev, active;

  always_comb begin
    scl_rise = scl_s & ~scl_p;
    scl_fall = ~scl_s & scl_p;
    start_ev = scl_s & scl_p & sda_p & ~sda_s;
    stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    active   = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);
  end

  always_comb begin
    phase_d   = phase_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    ack_d     = ack_q;
    left_d    = left_q;
    idx_d     = idx_q;
    wr_en_d   = 1'b0;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;

    if (start_ev) begin
      phase_d = PH_ADDR;
      bit_d   = '0;
      ack_d   = 1'b0;
    end else if (stop_ev) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      ack_d   = 1'b0;
    end else if (scl_fall && ack_q) begin
      // end of the ninth clock: release the line
      ack_d = 1'b0;
      bit_d = '0;
    end else if (active && scl_rise && (bit_q < 4'd8)) begin
      sh_d  = {sh_q[6:0], sda_s};
      bit_d = bit_q + 4'd1;
    end else if (active && scl_fall && (bit_q == 4'd8)) begin
      case (phase_q)
        PH_ADDR: begin
          if (sh_q == ADDR_BYTE) begin
            ack_d   = 1'b1;
            phase_d = PH_CMD;
          end else begin
            phase_d = PH_SKIP;
          end
        end
        PH_CMD: begin
          if (sh_q == 8'h00) begin
            ack_d   = 1'b1;
            phase_d = PH_COUNT;
          end else begin
            phase_d = PH_SKIP;
          end
        end
        PH_COUNT: begin
          if ((sh_q != 8'h00) && (sh_q <= 8'(MAX_COUNT))) begin
            ack_d   = 1'b1;
            left_d  = sh_q[CNT_W-1:0];
            idx_d   = '0;
            phase_d = PH_DATA;
          end else begin
            phase_d = PH_SKIP;
          end
        end
        PH_DATA: begin
          ack_d = 1'b1;
          if (idx_q < CNT_W'(RW_BYTES)) begin
            wr_en_d   = 1'b1;
            wr_idx_d  = idx_q[IDX_W-1:0];
            wr_data_d = sh_q;
          end
          idx_d  = idx_q + 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) phase_d = PH_SKIP;
        end
        default: phase_d = PH_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      ack_q     <= 1'b0;
      left_q    <= '0;
      idx_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      phase_q   <= phase_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      ack_q     <= ack_d;
      left_q    <= left_d;
      idx_q     <= idx_d;
      wr_en_q   <= wr_en_d;
      wr_idx_q  <= wr_idx_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign ack_pull = ack_q;
  assign wr_en    = wr_en_q;
  assign wr_idx   = wr_idx_q;
  assign wr_data  = wr_data_q;

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
  import smb_cfg_pkg::*;
#(
  parameter int RW_BYTES = 6,
  parameter int IDX_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  input  logic                    stop_live,
  input  logic [1:0]              strap_raw,
  output logic [(RW_BYTES+1)*8-1:0] bus
);

  logic [1:0] strap_q, strap_d;
  logic       taken_q, taken_d;

  always_comb begin
    strap_d = strap_q;
    taken_d = taken_q;
    if (!taken_q) begin
      strap_d = strap_raw;
      taken_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
      taken_q <= 1'b0;
    end else begin
      strap_q <= strap_d;
      taken_q <= taken_d;
    end
  end

  for (genvar g = 0; g < RW_BYTES; g++) begin : g_byte
    localparam logic [7:0] MASK = wr_mask(g);
    localparam logic [7:0] INIT = rst_value(g);
    logic [7:0] q, d;
    logic       hit;

    always_comb begin
      hit = wr_en && (wr_idx == IDX_W'(g));
      d   = hit ? ((q & ~MASK) | (wr_data & MASK)) : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= INIT;
      else        q <= d;
    end

    if (g == 0) begin : g_status
      assign bus[7:0] = {q[7], 1'b0, q[5], stop_live, q[3], strap_q, 1'b1};
    end else begin : g_plain
      assign bus[g*8 +: 8] = q;
    end
  end

  assign bus[RW_BYTES*8 +: 8] = ID_VALUE;

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         RW_BYTES    = 6,
  parameter int         MAX_COUNT   = 32,
  parameter logic [7:0] ADDR_BYTE   = 8'hD2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_in,
  input  logic                      sda_in,
  input  logic                      cpu_stop_n,
  input  logic [1:0]                strap_in,
  output logic                      sda_pull,
  output logic [(RW_BYTES+1)*8-1:0] cfg_bus
);

  localparam int IDX_W = (RW_BYTES > 1) ? $clog2(RW_BYTES) : 1;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [1:0]       line_s, line_p;
  logic             scl_s, scl_p, sda_s, sda_p;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  smb_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .raw    ({sda_in, scl_in}),
    .synced (line_s),
    .prev   (line_p)
  );

  assign scl_s = line_s[0];
  assign sda_s = line_s[1];
  assign scl_p = line_p[0];
  assign sda_p = line_p[1];

  smb_frame_engine #(
    .ADDR_BYTE (ADDR_BYTE),
    .MAX_COUNT (MAX_COUNT),
    .RW_BYTES  (RW_BYTES),
    .IDX_W     (IDX_W)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_s    (scl_s),
    .scl_p    (scl_p),
    .sda_s    (sda_s),
    .sda_p    (sda_p),
    .ack_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  smb_cfg_bank #(.RW_BYTES(RW_BYTES), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .stop_live (cpu_stop_n),
    .strap_raw (strap_in),
    .bus       (cfg_bus)
  );

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int RW_BYTES = 6,
  parameter int IDX_W    = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      scl_s,
  input logic                      sda_pull,
  input logic                      wr_en,
  input logic [IDX_W-1:0]          wr_idx,
  input logic [(RW_BYTES+1)*8-1:0] cfg_bus
);

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R10

  AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_s); // R10

  AST_WRITE_INSIDE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(RW_BYTES))); // R7

  AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_pull); // R5

  AST_CFG_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_bus[RW_BYTES*8-1:8])); // R5

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.RW_BYTES(RW_BYTES), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .scl_s    (scl_s),
  .sda_pull (sda_pull),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .cfg_bus  (cfg_bus)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m;
  logic        cpu_stop_n;
  logic [1:0]  strap_in;
  logic        sda_pull;
  logic [55:0] cfg_bus;
  wire         sda_line = sda_m & ~sda_pull;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  bit settle = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  int         m_phase = 0;  // 0 idle 1 addr 2 cmd 3 count 4 data 5 skip
  int         m_left = 0;
  int         m_idx = 0;
  logic [7:0] m_reg [6];
  logic [1:0] m_strap = 2'b10;

  always #5 clk = ~clk;

  smb_cfg_slave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .cpu_stop_n (cpu_stop_n),
    .strap_in   (strap_in),
    .sda_pull   (sda_pull),
    .cfg_bus    (cfg_bus)
  );

  function automatic logic [7:0] tb_mask(input int i);
    logic [7:0] m [6] = '{8'hA8, 8'h7F, 8'h7F, 8'hFF, 8'h3F, 8'h3F};
    return m[i];
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    if (i == 0) return {m_reg[0][7], 1'b0, m_reg[0][5], cpu_stop_n, m_reg[0][3], m_strap, 1'b1};
    if (i == 6) return 8'h08;
    return m_reg[i];
  endfunction

  function automatic bit model_byte(input logic [7:0] b);
    bit a = 1'b0;
    case (m_phase)
      1: if (b == 8'hD2) begin a = 1; m_phase = 2; end else m_phase = 5;
      2: if (b == 8'h00) begin a = 1; m_phase = 3; end else m_phase = 5;
      3: if (b >= 1 && b <= 32) begin a = 1; m_left = b; m_idx = 0; m_phase = 4; end
         else m_phase = 5;
      4: begin
        a = 1;
        if (m_idx < 6) m_reg[m_idx] = (m_reg[m_idx] & ~tb_mask(m_idx)) | (b & tb_mask(m_idx));
        m_idx++;
        m_left--;
        if (m_left == 0) m_phase = 5;
      end
      default: a = 0;
    endcase
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
    m_phase = 1;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
    m_phase = 0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    bit exp_ack;
    send_bits(b, 8);
    sda_m = 1'b1;
    settle = 1'b1;
    tick(H);
    exp_ack = model_byte(b);
    settle = 1'b0;
    scl_m = 1'b1; tick(H/2);
    chk(sda_pull == exp_ack, tag, "acknowledge", sda_pull, exp_ack);
    tick(H/2);
    scl_m = 1'b0; tick(H);
    chk(sda_pull == 1'b0, "R10", "release after ninth clock", sda_pull, 0);
  endtask

  // cycle-by-cycle compare of the register bus against the model
  always @(negedge clk) begin
    if (cmp_on && !settle && !done) begin
      for (int k = 0; k < 7; k++) begin
        checks++;
        if (cfg_bus[k*8 +: 8] !== exp_byte(k)) begin
          errors++;
          $display("FAIL R5 per-cycle byte %0d: actual %0h expected %0h", k, cfg_bus[k*8 +: 8], exp_byte(k));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reg = '{8'h00, 8'h07, 8'h7F, 8'hC7, 8'h3F, 8'h00};
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    cpu_stop_n = 1'b1; strap_in = 2'b10;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    strap_in = 2'b01;
    tick(2);
    // R1 reset state
    chk(cfg_bus[15:8]  == 8'h07, "R1", "byte1", cfg_bus[15:8], 8'h07);
    chk(cfg_bus[23:16] == 8'h7F, "R1", "byte2", cfg_bus[23:16], 8'h7F);
    chk(cfg_bus[31:24] == 8'hC7, "R1", "byte3", cfg_bus[31:24], 8'hC7);
    chk(cfg_bus[39:32] == 8'h3F, "R1", "byte4", cfg_bus[39:32], 8'h3F);
    chk(cfg_bus[47:40] == 8'h00, "R1", "byte5", cfg_bus[47:40], 8'h00);
    chk(cfg_bus[55:48] == 8'h08, "R1", "byte6", cfg_bus[55:48], 8'h08);
    chk(cfg_bus[7:0]   == 8'h15, "R9", "byte0 straps", cfg_bus[7:0], 8'h15);
    chk(sda_pull == 1'b0, "R10", "idle pull", sda_pull, 0);
    cmp_on = 1'b1;

    // R5 full write of the writable bank
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h00, "R3");
    send_byte(8'h06, "R4");
    send_byte(8'hFF, "R5");
    send_byte(8'h00, "R5");
    send_byte(8'hA5, "R5");
    send_byte(8'h5A, "R5");
    send_byte(8'hFF, "R5");
    send_byte(8'hC3, "R5");
    bus_stop();
    chk(cfg_bus[7:0] == 8'hBD, "R5", "byte0 masked", cfg_bus[7:0], 8'hBD);
    chk(cfg_bus[31:24] == 8'h5A, "R5", "byte3", cfg_bus[31:24], 8'h5A);

    // R2 foreign address and read direction
    bus_start();
    send_byte(8'hA0, "R2");
    send_byte(8'h00, "R2");
    send_byte(8'h01, "R2");
    send_byte(8'h00, "R2");
    bus_stop();
    bus_start();
    send_byte(8'hD3, "R2");
    send_byte(8'h00, "R2");
    bus_stop();
    chk(cfg_bus[7:0] == 8'hBD, "R2", "byte0 untouched", cfg_bus[7:0], 8'hBD);

    // R3 bad command
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h05, "R3");
    send_byte(8'h01, "R3");
    send_byte(8'h00, "R3");
    bus_stop();

    // R4 count out of range
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h00, "R3");
    send_byte(8'h00, "R4");
    send_byte(8'h00, "R4");
    bus_stop();
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h00, "R3");
    send_byte(8'h21, "R4");
    send_byte(8'h00, "R4");
    bus_stop();
    chk(cfg_bus[7:0] == 8'hBD, "R4", "byte0 untouched", cfg_bus[7:0], 8'hBD);

    // R7 maximum count, surplus indexes discarded
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h00, "R3");
    send_byte(8'h20, "R4");
    for (int i = 0; i < 32; i++) send_byte(8'((i * 37) + 3), "R7");
    send_byte(8'hFF, "R8");
    bus_stop();
    chk(cfg_bus[55:48] == 8'h08, "R7", "id byte", cfg_bus[55:48], 8'h08);

    // R8 bytes past the count
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h00, "R3");
    send_byte(8'h02, "R4");
    send_byte(8'h00, "R5");
    send_byte(8'h11, "R5");
    send_byte(8'h22, "R8");
    bus_stop();
    chk(cfg_bus[23:16] == exp_byte(2), "R8", "byte2 unchanged", cfg_bus[23:16], exp_byte(2));

    // R6 early stop, partial byte dropped
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h00, "R3");
    send_byte(8'h05, "R4");
    send_byte(8'h88, "R6");
    send_byte(8'h3C, "R6");
    send_bits(8'h00, 3);
    bus_stop();
    chk(cfg_bus[15:8] == 8'h3C, "R6", "byte1 kept", cfg_bus[15:8], 8'h3C);
    chk(cfg_bus[23:16] == exp_byte(2), "R6", "byte2 not written", cfg_bus[23:16], exp_byte(2));

    // R11 repeated start mid-transfer
    bus_start();
    send_byte(8'hD2, "R2");
    send_byte(8'h00, "R3");
    send_byte(8'h03, "R4");
    send_byte(8'h00, "R11");
    bus_start();
    send_byte(8'hD2, "R11");
    send_byte(8'h00, "R11");
    send_byte(8'h01, "R11");
    send_byte(8'hA8, "R11");
    bus_stop();
    chk(cfg_bus[7:0] == 8'hBD, "R11", "byte0 rewritten", cfg_bus[7:0], 8'hBD);

    // R9 live stop pin and latched straps
    cpu_stop_n = 1'b0;
    tick(1);
    chk(cfg_bus[4] == 1'b0, "R9", "stop bit low", cfg_bus[4], 0);
    chk(cfg_bus[2:1] == 2'b10, "R9", "strap held", cfg_bus[2:1], 2);
    cpu_stop_n = 1'b1;
    tick(1);
    chk(cfg_bus[4] == 1'b1, "R9", "stop bit high", cfg_bus[4], 1);
    chk(cfg_bus[6] == 1'b0 && cfg_bus[0] == 1'b1, "R9", "fixed bits", cfg_bus[7:0], 8'hBD);

    tick(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule